// File: doc/BRIEF.md
# Register Block Transfer Sequencer

This block moves a run of architectural registers between a register file and consecutive words of memory. It starts at a chosen register and continues up to and including the highest-numbered register, which is 7 with the default parameters. At each step it moves one register through a single-word memory port and then advances the memory address by one word. One bit of the format code chooses the base-register file or the general-register file. A direction input chooses whether registers are loaded from memory or stored to it.

While it walks the addresses, the sequencer watches the address bit of weight 0x20. That bit marks which 32-byte half-file the transfer falls in. If the bit changes partway through a run, the legacy machine model stops with an address-specification trap, and newer models carry on. The trap is raised before the memory access of the step that crossed. A misaligned start traps before any access takes place. A memory fault ends the run at once. Registers or memory words already moved stay as they are. Instruction decode and the memory system itself sit outside this block.

Top module: `regblk_xfer`

## Requirements
- R1: A start whose format code low two bits (fmt_code[1:0]) or start address low two bits are not both zero ends with done and trap_spec high, and makes no memory request or register write.
- R2: Steps run from start_reg up to register 7. At each step mem_addr is 4 higher and reg_idx is 1 higher than at the step before. The first step uses start_addr and start_reg.
- R3: With legacy_model high, a step whose address bit 5 differs from bit 5 of start_addr makes no access. The run then ends with done and trap_spec. Registers moved before that step keep their new values.
- R4: With legacy_model low, a change in address bit 5 has no effect, and the run completes every register up to 7.
- R5: fmt_code[2]=1 drives reg_base high so the base-register file is transferred. fmt_code[2]=0 selects the general-register file. The other file is left untouched.
- R6: to_memory=1 writes reg_rdata to memory with mem_we high. to_memory=0 writes mem_rdata into the register through reg_we and reg_wdata, and mem_we stays low.
- R7: A step holds mem_req, mem_addr and reg_idx steady until mem_ready. Each step lasts exactly as long as the memory takes to answer.
- R8: mem_fault together with mem_ready ends the run with done and mem_err and no register write for that step. Earlier steps are not undone, and trap_spec stays low.
- R9: done is a one-cycle pulse. trap_spec and mem_err are high only together with done. A start while busy is ignored.
- R10: After reset, and after a reset that arrives partway through a run, busy, done, mem_req and reg_we are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transfer (sampled when idle) |
| start_reg | input | 3 | First register number |
| start_addr | input | 24 | First memory byte address |
| fmt_code | input | 3 | Bit 2 selects the base file; bits 1:0 must be zero |
| to_memory | input | 1 | 1 = store registers, 0 = load registers |
| legacy_model | input | 1 | 1 = half-file crossing traps |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| trap_spec | output | 1 | Address-specification trap, valid with done |
| mem_err | output | 1 | Memory fault ended the run, valid with done |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 24 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| mem_ready | input | 1 | Memory completes the request |
| mem_fault | input | 1 | Memory reports a fault, valid with mem_ready |
| reg_base | output | 1 | 1 = base-register file, 0 = general file |
| reg_idx | output | 3 | Register number being transferred |
| reg_rdata | input | 32 | Register file read data |
| reg_we | output | 1 | Register file write enable |
| reg_wdata | output | 32 | Register file write data |

## Verification
The hardest case to reach is a trap in the middle of a run. It needs a start address close enough below a 32-byte boundary that the walk crosses bit 5 before register 7, and it needs the legacy model selected. The stimulus table sets this up at several offsets and wait latencies. Each of those runs is paired with the same addresses on the newer model, and the bench compares how many registers moved and what memory and both files hold afterwards. A memory fault injected at a chosen address covers an early stop on the fault path.

// File: rtl/regblk_pkg.sv
// Shared types for the register block transfer sequencer.
package regblk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_FIN  = 2'd2
    } xfer_state_t;
endpackage

// File: rtl/regblk_walker.sv
// Register/address walker.
// Holds the current register number and byte address of a run and steps
// them together. It also flags when the watched address bit no longer
// matches the value it had at the start of the run.
// Assumes: load and advance never occur in the same cycle.
module regblk_walker #(
    parameter int ADDR_W  = 24,
    parameter int REG_CNT = 8,
    parameter int BND_BIT = 5,
    localparam int REG_W  = $clog2(REG_CNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  logic [REG_W-1:0]  first_reg,
    input  logic [ADDR_W-1:0] first_addr,
    output logic [REG_W-1:0]  cur_reg,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              at_last,
    output logic              crossed
);
    localparam logic [REG_W-1:0]  LAST_REG = REG_W'(REG_CNT - 1);
    localparam logic [ADDR_W-1:0] WORD_INC = ADDR_W'(4);

    logic ref_bit;

    // Capture the start point, then step one register and one word per advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_reg  <= '0;
            cur_addr <= '0;
            ref_bit  <= 1'b0;
        end else if (load) begin
            cur_reg  <= first_reg;
            cur_addr <= first_addr;
            ref_bit  <= first_addr[BND_BIT];
        end else if (advance) begin
            cur_reg  <= cur_reg + REG_W'(1);
            cur_addr <= cur_addr + WORD_INC;
        end
    end

    // Last-register and half-file crossing indications for the current step.
    always_comb begin
        at_last = (cur_reg == LAST_REG);
        crossed = (cur_addr[BND_BIT] != ref_bit);
    end
endmodule

// File: rtl/regblk_ctrl.sv
// Transfer controller.
// Accepts a start when idle and latches the run options. It issues one
// memory request per step and waits on the ready handshake. A run ends on
// the last register, a misaligned start, a legacy-model half-file
// crossing, or a memory fault; done is pulsed with the cause flags.
// Assumes: mem_fault is meaningful only together with mem_ready.
module regblk_ctrl
    import regblk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic misaligned,
    input  logic use_base,
    input  logic store_dir,
    input  logic legacy,
    input  logic at_last,
    input  logic crossed,
    input  logic mem_ready,
    input  logic mem_fault,
    output logic load,
    output logic advance,
    output logic step_ok,
    output logic mem_req,
    output logic base_q,
    output logic store_q,
    output logic busy,
    output logic done,
    output logic trap_spec,
    output logic mem_err
);
    xfer_state_t state, state_nx;
    logic legacy_q;
    logic spec_q, err_q;
    logic step_trap, handshake;

    // Per-cycle decode of the current step.
    always_comb begin
        load      = (state == ST_IDLE) && start;
        step_trap = (state == ST_XFER) && crossed && legacy_q;
        mem_req   = (state == ST_XFER) && !step_trap;
        handshake = mem_req && mem_ready;
        step_ok   = handshake && !mem_fault;
        advance   = step_ok && !at_last;
    end

    // Next-state selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (load) state_nx = misaligned ? ST_FIN : ST_XFER;
            ST_XFER: if (step_trap || (handshake && (mem_fault || at_last)))
                         state_nx = ST_FIN;
            ST_FIN:  state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State, latched run options and end-cause flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            legacy_q <= 1'b0;
            base_q   <= 1'b0;
            store_q  <= 1'b0;
            spec_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            state <= state_nx;
            if (load) begin
                legacy_q <= legacy;
                base_q   <= use_base;
                store_q  <= store_dir;
                spec_q   <= misaligned;
                err_q    <= 1'b0;
            end else begin
                if (step_trap) spec_q <= 1'b1;
                if (handshake && mem_fault) err_q <= 1'b1;
            end
        end
    end

    // Status outputs; cause flags are only exposed with done.
    always_comb begin
        busy      = (state != ST_IDLE);
        done      = (state == ST_FIN);
        trap_spec = done && spec_q;
        mem_err   = done && err_q;
    end
endmodule

// File: rtl/regblk_xfer.sv
// Register block transfer sequencer, top level.
// Moves registers start_reg..REG_CNT-1 of the selected file to or from
// consecutive memory words, one word per ready handshake.
// Assumes: the register file read port is combinational on reg_base/reg_idx.
module regblk_xfer #(
    parameter int ADDR_W  = 24,
    parameter int DATA_W  = 32,
    parameter int REG_CNT = 8,
    parameter int BND_BIT = 5,
    localparam int REG_W  = $clog2(REG_CNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [REG_W-1:0]  start_reg,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [2:0]        fmt_code,
    input  logic              to_memory,
    input  logic              legacy_model,
    output logic              busy,
    output logic              done,
    output logic              trap_spec,
    output logic              mem_err,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    input  logic              mem_fault,
    output logic              reg_base,
    output logic [REG_W-1:0]  reg_idx,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              reg_we,
    output logic [DATA_W-1:0] reg_wdata
);
    logic misaligned, load, advance, step_ok, at_last, crossed, store_q;

    // Start is rejected when format or address is not word aligned.
    always_comb misaligned = (fmt_code[1:0] != 2'b00) || (start_addr[1:0] != 2'b00);

    regblk_walker #(
        .ADDR_W (ADDR_W),
        .REG_CNT(REG_CNT),
        .BND_BIT(BND_BIT)
    ) u_walker (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .advance   (advance),
        .first_reg (start_reg),
        .first_addr(start_addr),
        .cur_reg   (reg_idx),
        .cur_addr  (mem_addr),
        .at_last   (at_last),
        .crossed   (crossed)
    );

    regblk_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .misaligned(misaligned),
        .use_base  (fmt_code[2]),
        .store_dir (to_memory),
        .legacy    (legacy_model),
        .at_last   (at_last),
        .crossed   (crossed),
        .mem_ready (mem_ready),
        .mem_fault (mem_fault),
        .load      (load),
        .advance   (advance),
        .step_ok   (step_ok),
        .mem_req   (mem_req),
        .base_q    (reg_base),
        .store_q   (store_q),
        .busy      (busy),
        .done      (done),
        .trap_spec (trap_spec),
        .mem_err   (mem_err)
    );

    // Data steering between the memory port and the register file ports.
    always_comb begin
        mem_we    = mem_req && store_q;
        mem_wdata = reg_rdata;
        reg_we    = step_ok && !store_q;
        reg_wdata = mem_rdata;
    end
endmodule

// File: rtl/regblk_xfer_chk.sv
// Protocol checker for regblk_xfer, attached by bind.
module regblk_xfer_chk #(
    parameter int ADDR_W  = 24,
    parameter int REG_CNT = 8,
    localparam int REG_W  = $clog2(REG_CNT)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              trap_spec,
    input logic              mem_err,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ready,
    input logic              mem_fault,
    input logic [REG_W-1:0]  reg_idx,
    input logic              reg_we
);
    localparam logic [REG_W-1:0] LAST_REG = REG_W'(REG_CNT - 1);

    AST_ALIGNED_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00)); // R1
    AST_STEP_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && !mem_fault && reg_idx != LAST_REG) |=>
        (!mem_req || (mem_addr == $past(mem_addr) + ADDR_W'(4) &&
                      reg_idx == $past(reg_idx) + REG_W'(1)))); // R2
    AST_LOAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (mem_ready && !mem_fault && !mem_we)); // R6
    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(reg_idx))); // R7
    AST_FAULT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && mem_fault) |=> (done && mem_err && !trap_spec)); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_FLAG_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_spec || mem_err) |-> done); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !reg_we)); // R10
endmodule

bind regblk_xfer regblk_xfer_chk #(
    .ADDR_W (ADDR_W),
    .REG_CNT(REG_CNT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .trap_spec(trap_spec),
    .mem_err  (mem_err),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_ready(mem_ready),
    .mem_fault(mem_fault),
    .reg_idx  (reg_idx),
    .reg_we   (reg_we)
);

// File: tb/tb_regblk_xfer.sv
module tb_regblk_xfer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  start_reg = '0;
    logic [23:0] start_addr = '0;
    logic [2:0]  fmt_code = '0;
    logic        to_memory = 1'b0;
    logic        legacy_model = 1'b0;
    logic        busy, done, trap_spec, mem_err, mem_req, mem_we;
    logic [23:0] mem_addr;
    logic [31:0] mem_wdata, reg_wdata, reg_rdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ready = 1'b0, mem_fault = 1'b0;
    logic        reg_base, reg_we;
    logic [2:0]  reg_idx;

    always #10 clk = ~clk;

    regblk_xfer dut (.*);

    logic [31:0] mem [64];
    logic [31:0] gpr [8];
    logic [31:0] bpr [8];
    assign reg_rdata = reg_base ? bpr[reg_idx] : gpr[reg_idx];

    int checks = 0, fails = 0;
    int lat_cfg = 0, wcnt = 0;
    int hs_cnt = 0, req_cyc = 0, bad_seq = 0;
    logic [23:0] exp_base;
    logic [2:0]  exp_sreg;
    logic        fault_en = 1'b0;
    logic [7:0]  fault_addr = '0;

    // sreg(3) addr(8) fmt(3) store(1) legacy(1) lat(2) count(4) trap(1)
    localparam int NV = 9;
    localparam logic [22:0] VECS [NV] = '{
        {3'd0, 8'h40, 3'd0, 1'b0, 1'b0, 2'd0, 4'd8, 1'b0},
        {3'd5, 8'h80, 3'd4, 1'b1, 1'b0, 2'd1, 4'd3, 1'b0},
        {3'd0, 8'h10, 3'd0, 1'b1, 1'b1, 2'd0, 4'd4, 1'b1},
        {3'd0, 8'h10, 3'd0, 1'b1, 1'b0, 2'd0, 4'd8, 1'b0},
        {3'd2, 8'h18, 3'd4, 1'b0, 1'b1, 2'd2, 4'd2, 1'b1},
        {3'd7, 8'hF0, 3'd0, 1'b0, 1'b1, 2'd1, 4'd1, 1'b0},
        {3'd3, 8'h40, 3'd1, 1'b0, 1'b0, 2'd0, 4'd0, 1'b1},
        {3'd3, 8'h42, 3'd0, 1'b1, 1'b0, 2'd0, 4'd0, 1'b1},
        {3'd4, 8'h3C, 3'd4, 1'b1, 1'b1, 2'd0, 4'd1, 1'b1}
    };

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic init_storage();
        for (int i = 0; i < 64; i++) mem[i] = 32'hA500_0000 | i;
        for (int i = 0; i < 8; i++) begin
            gpr[i] = 32'h1100_0000 | i;
            bpr[i] = 32'h2200_0000 | i;
        end
    endtask

    // Memory responder and handshake monitor, all away from the rising edge.
    always @(negedge clk) begin
        mem_ready = 1'b0;
        mem_fault = 1'b0;
        if (mem_req) begin
            req_cyc++;
            if (wcnt == lat_cfg) begin
                mem_ready = 1'b1;
                mem_fault = fault_en && (mem_addr[7:0] == fault_addr);
                mem_rdata = mem[mem_addr[7:2]];
                wcnt = 0;
                if (!mem_fault) begin
                    if (mem_addr != exp_base + 24'(4 * hs_cnt) || reg_idx != exp_sreg + 3'(hs_cnt))
                        bad_seq++;
                    hs_cnt++;
                end
            end else wcnt++;
        end else wcnt = 0;
        #1;
        if (reg_we) begin
            if (reg_base) bpr[reg_idx] = reg_wdata;
            else gpr[reg_idx] = reg_wdata;
        end
        if (mem_we && mem_ready && !mem_fault) mem[mem_addr[7:2]] = mem_wdata;
    end

    task automatic run_xfer(input logic [2:0] sreg, input logic [7:0] addr, input logic [2:0] fmt,
                            input bit st, input bit old, input int lat, input int cnt,
                            input bit exp_trap, input bit exp_err, input bit poke, input string tag);
        int cyc;
        int bad;
        logic [31:0] m0 [64];
        logic [31:0] g0 [8];
        logic [31:0] b0 [8];
        init_storage();
        m0 = mem; g0 = gpr; b0 = bpr;
        lat_cfg = lat; hs_cnt = 0; req_cyc = 0; bad_seq = 0;
        exp_base = {16'd0, addr}; exp_sreg = sreg;
        @(negedge clk);
        start = 1'b1; start_reg = sreg; start_addr = {16'd0, addr};
        fmt_code = fmt; to_memory = st; legacy_model = old;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 400) begin
            if (poke && cyc == 3) begin
                start = 1'b1; start_reg = 3'd6; start_addr = 24'h80; fmt_code = 3'd4;
            end else start = 1'b0;
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        check(done, {tag, " R9 done seen"}, done, 1);
        check(trap_spec == exp_trap, {tag, " R1/R3 trap_spec"}, trap_spec, exp_trap);
        check(mem_err == exp_err, {tag, " R8 mem_err"}, mem_err, exp_err);
        check(hs_cnt == cnt, {tag, " R2/R3/R4 registers moved"}, hs_cnt, cnt);
        check(bad_seq == 0, {tag, " R2 address/register sequence"}, bad_seq, 0);
        if (!exp_err)
            check(req_cyc == cnt * (lat + 1), {tag, " R7 request cycles"}, req_cyc, cnt * (lat + 1));
        // Expected storage contents after the run.
        for (int k = 0; k < cnt; k++) begin
            if (st) m0[addr[7:2] + k] = fmt[2] ? b0[sreg + k] : g0[sreg + k];
            else if (fmt[2]) b0[sreg + k] = m0[addr[7:2] + k];
            else g0[sreg + k] = m0[addr[7:2] + k];
        end
        bad = 0;
        for (int i = 0; i < 64; i++) if (mem[i] != m0[i]) bad++;
        for (int i = 0; i < 8; i++) if (gpr[i] != g0[i] || bpr[i] != b0[i]) bad++;
        check(bad == 0, {tag, " R5/R6 storage contents"}, bad, 0);
        @(negedge clk);
        check(!done && !trap_spec && !mem_err, {tag, " R9 done one cycle"}, done, 0);
    endtask

    task automatic finish_up();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        checks++; fails++;
        $display("FAIL watchdog R9 actual=hung expected=done");
        finish_up();
    end

    initial begin
        init_storage();
        repeat (3) @(negedge clk);
        check(!busy && !done && !mem_req && !reg_we, "R10 reset state", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !mem_req, "R10 idle after reset", mem_req, 0);

        for (int v = 0; v < NV; v++) begin
            logic [22:0] e;
            e = VECS[v];
            run_xfer(e[22:20], e[19:12], e[11:9], e[8], e[7], int'(e[6:5]), int'(e[4:1]),
                     e[0], 1'b0, 1'b0, $sformatf("vec%0d", v));
        end

        // R8: fault on third word of a load, earlier registers stay loaded.
        fault_en = 1'b1; fault_addr = 8'h48;
        run_xfer(3'd0, 8'h40, 3'd0, 1'b0, 1'b0, 0, 2, 1'b0, 1'b1, 1'b0, "fault");
        fault_en = 1'b0;

        // R9: a second start while busy has no effect on the run.
        run_xfer(3'd0, 8'h40, 3'd0, 1'b0, 1'b0, 2, 8, 1'b0, 1'b0, 1'b1, "busy_start");

        // R10: reset partway through a run.
        lat_cfg = 1;
        @(negedge clk);
        start = 1'b1; start_reg = 3'd0; start_addr = 24'h40; fmt_code = 3'd0;
        to_memory = 1'b0; legacy_model = 1'b0;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        check(busy, "R10 running before reset", busy, 1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(!busy && !done && !mem_req && !reg_we, "R10 mid-run reset", busy, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy && !mem_req, "R10 stays idle", mem_req, 0);
        finish_up();
    end
endmodule